// File: doc/BRIEF.md
# Serial Shadow-RAM Command Front End

This block is the serial slave side of a small shadowed memory of 16 words of 16 bits. A host drives a select line, a serial clock and a serial data line in clock mode 0 or 3. The block works entirely in its own system clock domain and oversamples the three serial inputs. It locates the start of each instruction, gathers the 8-bit command word and splits it into a word address and an operation. It then either runs a 16-bit data phase against the RAM port or sends a one-cycle request to the neighbouring store/recall controller.

While CS is low, leading zeros on the data line are skipped, so the serial clock may run freely before a command starts. A read is recognised from its first seven bits. The word is fetched early so that its most significant bit is on the output during the ninth serial clock. A write gathers data bits until the host deselects, and only then is one word committed to the RAM. A short write commits whatever bits arrived. A long write keeps the last sixteen.

The controller supplies two inputs. One gives permission for RAM writes. The other is a busy flag, and every command decoded while it is high is discarded.

Top module: `nvs_spi_front`

## Requirements
- R1: While CS is low and before a command has started, rising SCK edges with SI = 0 are skipped. The first rising edge with SI = 1 supplies bit 7 of the instruction.
- R2: The instruction is 8 bits, sampled on rising SCK and sent most significant bit first. Bit 7 is 1, bits 6..3 hold the word address and bits 2..0 hold the operation code.
- R3: Operation codes 000, 001, 010, 100 and 101 raise exactly one one-cycle pulse per instruction. The pulse appears on cmd_wen_clr, cmd_store, cmd_auto_en, cmd_wen_set and cmd_recall respectively.
- R4: When bits 2..1 are 11 the instruction is a read and bit 0 is ignored. From the falling SCK edge that follows the 8th rising edge, SO carries the addressed word, bit 15 first, with one new bit on each of 16 falling edges.
- R5: so_oe is low after reset, during the instruction bits and after CS is high. It is high only while the 16 read bits are being driven.
- R6: Operation code 011 is a write. Data bits that follow it are shifted in most significant bit first. When CS goes high, one ram_we pulse writes them to the address carried by the instruction.
- R7: A write of k data bits with 0 < k < 16 stores a word whose low k bits are the received bits, the first received bit being bit k-1, and whose upper bits are 0. A write with no data bits stores nothing.
- R8: A write with more than 16 data bits stores the last 16 bits received.
- R9: A write is committed only if wen_allow is high at the moment CS goes high. Otherwise there is no ram_we pulse and the word is unchanged.
- R10: A command decoded while ctrl_busy is high is dropped. That means no pulse, no RAM write and no SO drive. The decode point is the 7th instruction bit for reads and the 8th bit for every other operation.
- R11: CS high abandons a partly received instruction. The next frame starts framing afresh.
- R12: SCK is static. A pause of any length between serial edges does not change the result.
- R13: After a non-data command completes, further SCK edges in the same frame are ignored until CS goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out drive enable |
| ram_addr | output | 4 | RAM word address |
| ram_wdata | output | 16 | RAM write word |
| ram_we | output | 1 | RAM write strobe, one cycle |
| ram_rdata | input | 16 | RAM read word for ram_addr |
| ctrl_busy | input | 1 | Controller busy; commands are dropped |
| wen_allow | input | 1 | Controller permits RAM writes |
| cmd_wen_clr | output | 1 | Pulse: clear write permission |
| cmd_store | output | 1 | Pulse: store request |
| cmd_auto_en | output | 1 | Pulse: enable automatic store |
| cmd_wen_set | output | 1 | Pulse: set write permission |
| cmd_recall | output | 1 | Pulse: recall request |

## Verification
The assertions assume that each SCK phase lasts several system clocks, longer than the four-cycle path through the synchronizer and edge stage. They also assume that CS settles before the first serial edge of a frame and after the last one, so that an edge and a select change are never seen in the same cycle. They further assume that ram_rdata follows ram_addr combinationally and that ctrl_busy and wen_allow change only between frames. The stimulus meets these assumptions by holding every SCK phase for eight system clocks, or far longer during pauses. It also leaves a gap of eight or more clocks around every select change and changes the controller inputs only while CS is high.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int OP_W  = 3;
  localparam int NSTRB = 5;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_INSTR,
    ST_WDATA,
    ST_RWAIT,
    ST_RDATA,
    ST_HOLD
  } fr_state_t;

  // bits 2..1 of the opcode both set mark a read
  function automatic logic is_read_pair(input logic [1:0] top2);
    return top2 == 2'b11;
  endfunction

  function automatic logic is_write_op(input logic [OP_W-1:0] op);
    return op == 3'b011;
  endfunction

  // one-hot pulse vector: {recall, wen_set, auto_en, store, wen_clr}
  function automatic logic [NSTRB-1:0] strobe_of(input logic [OP_W-1:0] op);
    case (op)
      3'b000:  return 5'b00001;
      3'b001:  return 5'b00010;
      3'b010:  return 5'b00100;
      3'b100:  return 5'b01000;
      3'b101:  return 5'b10000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {2{RST_VAL[i]}};
      else        pipe <= {pipe[0], din[i]};
    end
    assign lvl[i] = pipe[1];
  end
endmodule

// File: rtl/nvs_edge.sv
module nvs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/nvs_framer.sv
module nvs_framer
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sck_rise,
  input  logic              si_lvl,
  input  logic              busy,
  input  logic              wen_allow,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              we,
  output logic [NSTRB-1:0]  strb,
  output logic              rd_load
);
  localparam int INS_W = 1 + ADDR_W + OP_W;
  localparam int HW    = INS_W - 1;
  localparam int BW    = $clog2(INS_W + 1);
  localparam int DW    = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] AT_RD  = BW'(INS_W - 2);
  localparam logic [BW-1:0] AT_OP  = BW'(INS_W - 1);
  localparam logic [DW-1:0] D_FULL = DW'(DATA_W);

  fr_state_t         st;
  logic [HW-1:0]     hist;
  logic [HW-1:0]     nxt;
  logic [BW-1:0]     bitn;
  logic [DW-1:0]     wcnt;
  logic [OP_W-1:0]   op8;

  assign nxt = {hist[HW-2:0], si_lvl};
  assign op8 = {hist[1:0], si_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HUNT; hist <= '0; bitn <= '0; wcnt <= '0;
      addr <= '0; wdata <= '0; we <= 1'b0; strb <= '0; rd_load <= 1'b0;
    end else begin
      we <= 1'b0; strb <= '0; rd_load <= 1'b0;
      if (cs_hi) begin
        if (st == ST_WDATA && wcnt != '0 && wen_allow) we <= 1'b1;
        st <= ST_HUNT; bitn <= '0;
      end else if (sck_rise) begin
        case (st)
          ST_HUNT: if (si_lvl) begin
            hist <= HW'(1); bitn <= BW'(1); st <= ST_INSTR;
          end
          ST_INSTR: begin
            hist <= nxt;
            bitn <= bitn + 1'b1;
            if (bitn == AT_RD && is_read_pair(nxt[1:0])) begin
              if (busy) st <= ST_HOLD;
              else begin
                addr <= nxt[OP_W-1 +: ADDR_W];
                st   <= ST_RWAIT;
              end
            end else if (bitn == AT_OP) begin
              if (busy) st <= ST_HOLD;
              else if (is_write_op(op8)) begin
                addr <= hist[OP_W-1 +: ADDR_W];
                wdata <= '0; wcnt <= '0; st <= ST_WDATA;
              end else begin
                strb <= strobe_of(op8);
                st   <= ST_HOLD;
              end
            end
          end
          ST_RWAIT: begin
            rd_load <= 1'b1;
            st      <= ST_RDATA;
          end
          ST_WDATA: begin
            wdata <= {wdata[DATA_W-2:0], si_lvl};
            if (wcnt != D_FULL) wcnt <= wcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT && sck_rise && !si_lvl && !cs_hi) |=> st == ST_HUNT);
  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb, we}));
  // R9
  we_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $past(wen_allow));
  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb) |-> !$past(busy));
endmodule

// File: rtl/nvs_rd_shift.sv
module nvs_rd_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              sck_fall,
  output logic              so,
  output logic              oe
);
  localparam int DW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [DW-1:0]     left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; so <= 1'b0; oe <= 1'b0;
    end else if (cs_hi) begin
      left <= '0; oe <= 1'b0;
    end else if (load) begin
      sh <= ld_data; left <= DW'(DATA_W);
    end else if (sck_fall) begin
      if (left != '0) begin
        so   <= sh[DATA_W-1];
        sh   <= {sh[DATA_W-2:0], 1'b0};
        oe   <= 1'b1;
        left <= left - 1'b1;
      end else begin
        oe <= 1'b0;
      end
    end
  end

  // R4
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(sck_fall));
  // R5
  oe_off_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !oe);
endmodule

// File: rtl/nvs_spi_front.sv
module nvs_spi_front
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so_data,
  output logic              so_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              ctrl_busy,
  input  logic              wen_allow,
  output logic              cmd_wen_clr,
  output logic              cmd_store,
  output logic              cmd_auto_en,
  output logic              cmd_wen_set,
  output logic              cmd_recall
);
  logic [2:0]       lvl;
  logic             sck_rise, sck_fall;
  logic             rd_load;
  logic [NSTRB-1:0] strb;

  nvs_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({si, sck, cs_n}), .lvl(lvl)
  );

  nvs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl[1]), .rise(sck_rise), .fall(sck_fall)
  );

  nvs_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .cs_hi(lvl[0]), .sck_rise(sck_rise),
    .si_lvl(lvl[2]), .busy(ctrl_busy), .wen_allow(wen_allow),
    .addr(ram_addr), .wdata(ram_wdata), .we(ram_we), .strb(strb),
    .rd_load(rd_load)
  );

  nvs_rd_shift #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cs_hi(lvl[0]), .load(rd_load),
    .ld_data(ram_rdata), .sck_fall(sck_fall), .so(so_data), .oe(so_oe)
  );

  assign {cmd_recall, cmd_wen_set, cmd_auto_en, cmd_store, cmd_wen_clr} = strb;
endmodule

// File: tb/nvs_spi_front_bench.sv
module nvs_spi_front_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sck, si, so_data, so_oe, ram_we, ctrl_busy, wen_allow;
  logic [3:0]  ram_addr;
  logic [15:0] ram_wdata, ram_rdata;
  logic cmd_wen_clr, cmd_store, cmd_auto_en, cmd_wen_set, cmd_recall;

  nvs_spi_front u_nvs_spi_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so_data(so_data), .so_oe(so_oe), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .ctrl_busy(ctrl_busy), .wen_allow(wen_allow),
    .cmd_wen_clr(cmd_wen_clr), .cmd_store(cmd_store),
    .cmd_auto_en(cmd_auto_en), .cmd_wen_set(cmd_wen_set),
    .cmd_recall(cmd_recall)
  );

  // RAM model on the bench side
  logic [15:0] mem [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (ram_we) mem[ram_addr] <= ram_wdata;
  end
  assign ram_rdata = mem[ram_addr];

  typedef struct {int kind; logic [3:0] a; logic [15:0] d; string tag;} item_t;
  item_t exq[$];
  logic [15:0] shadow [16];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  localparam int H = 8;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: kinds 0 wen_clr,1 store,2 auto_en,3 wen_set,4 recall,5 write
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] sv;
      sv = {cmd_recall, cmd_wen_set, cmd_auto_en, cmd_store, cmd_wen_clr};
      if (sv != 0 || ram_we) begin
        int k;
        k = 5;
        if (!ram_we) for (int i = 0; i < 5; i++) if (sv[i]) k = i;
        n_chk++;
        if (exq.size() == 0) begin
          n_bad++;
          $display("FAIL R3 unexpected event actual=%0d expected=none", k);
        end else begin
          item_t e;
          e = exq.pop_front();
          if (k != e.kind || $countones({sv, ram_we}) != 1 ||
              (k == 5 && (ram_addr !== e.a || ram_wdata !== e.d))) begin
            n_bad++;
            $display("FAIL %s actual=%0d/%h/%h expected=%0d/%h/%h",
                     e.tag, k, ram_addr, ram_wdata, e.kind, e.a, e.d);
          end
        end
      end
    end
  end

  function automatic logic [2:0] op_of(input int kind);
    case (kind)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b010;
      3: return 3'b100; default: return 3'b101;
    endcase
  endfunction

  task automatic pulse(input logic b, input int half, output logic so_s, output logic oe_s);
    @(negedge clk); si = b; sck = 1'b0;
    repeat (half) @(negedge clk);
    so_s = so_data; oe_s = so_oe;
    sck = 1'b1;
    repeat (half) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic s, o;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], H, s, o);
  endtask

  task automatic frame_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_off();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
    sck = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic cmd(input int kind, input logic [3:0] a, input int lead0, input string tag);
    if (!ctrl_busy) exq.push_back('{kind, 4'h0, 16'h0, tag});
    frame_on();
    if (lead0 > 0) send_bits(32'h0, lead0);
    send_bits({24'h0, 1'b1, a, op_of(kind)}, 8);
    frame_off();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] data, input int n, input string tag);
    logic [15:0] e;
    e = (n >= 16) ? data[15:0] : 16'(data & ((32'd1 << n) - 1));
    if (n > 0 && wen_allow && !ctrl_busy) begin
      exq.push_back('{5, a, e, tag});
      shadow[a] = e;
    end
    frame_on();
    send_bits({24'h0, 1'b1, a, 3'b011}, 8);
    if (n > 0) send_bits(data, n);
    frame_off();
  endtask

  task automatic rd(input logic [3:0] a, input int pause_at, input string tag);
    logic s, o, any_on, all_on, pre_on;
    logic [15:0] w;
    logic [7:0] ins;
    ins = {1'b1, a, 3'b110};
    pre_on = 0; any_on = 0; all_on = 1; w = '0;
    frame_on();
    for (int i = 7; i >= 0; i--) begin
      pulse(ins[i], H, s, o);
      pre_on |= o;
    end
    for (int j = 0; j < 16; j++) begin
      pulse(1'b0, (j == pause_at) ? 150 : H, s, o);
      w[15 - j] = s;
      any_on |= o; all_on &= o;
    end
    chk({tag, " R5 oe low during instruction"}, {31'h0, pre_on}, 32'h0);
    if (ctrl_busy) begin
      chk({tag, " R10 busy read never drives"}, {31'h0, any_on}, 32'h0);
    end else begin
      chk({tag, " R4 oe high over data"}, {31'h0, all_on}, 32'h1);
      chk({tag, " R4 read word"}, {16'h0, w}, {16'h0, shadow[a]});
    end
    frame_off();
    chk({tag, " R5 oe low after deselect"}, {31'h0, so_oe}, 32'h0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    rst_n = 0; cs_n = 1; sck = 0; si = 0; ctrl_busy = 0; wen_allow = 1;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R5 reset oe", {31'h0, so_oe}, 32'h0);

    wr(4'd3, 32'h0000_A5C3, 16, "R6 full write");
    rd(4'd3, -1, "R6");
    wr(4'd9, 32'h0000_1234, 16, "R2 address decode");
    rd(4'd9, -1, "R2");
    rd(4'd3, -1, "R2 other address");

    wr(4'd5, 32'h0000_002D, 6, "R7 short write");
    rd(4'd5, -1, "R7");
    wr(4'd5, 32'h0, 0, "R7 empty write");
    rd(4'd5, -1, "R7 empty keeps");

    wr(4'd7, 32'hDEAD_BEEF, 24, "R8 long write");
    rd(4'd7, -1, "R8");

    wen_allow = 0;
    wr(4'd3, 32'h0000_FFFF, 16, "R9 no permission");
    wen_allow = 1;
    rd(4'd3, -1, "R9");

    for (int k = 0; k < 5; k++) cmd(k, 4'(k), 0, "R3 opcode pulse");
    cmd(4, 4'hA, 6, "R1 leading zeros");
    cmd(1, 4'h0, 3, "R1 leading zeros store");

    ctrl_busy = 1;
    cmd(1, 4'h0, 0, "R10 busy store");
    wr(4'd2, 32'h0000_7777, 16, "R10 busy write");
    rd(4'd2, -1, "R10");
    ctrl_busy = 0;
    rd(4'd2, -1, "R10 after busy");

    frame_on();
    send_bits(32'h10, 5);
    frame_off();
    cmd(3, 4'h0, 0, "R11 fresh after abandon");

    exq.push_back('{3, 4'h0, 16'h0, "R13 one command per frame"});
    frame_on();
    send_bits({24'h0, 8'b1000_0100}, 8);
    send_bits({24'h0, 8'b1000_0101}, 8);
    frame_off();

    rd(4'd9, 3, "R12 paused clock");
    rd(4'd7, 12, "R12 paused clock late");

    repeat (50) @(negedge clk);
    chk("R3 queue drained", exq.size(), 32'h0);
    summary();
  end
endmodule